// File: doc/BRIEF.md
# Serial Receive Buffer with Threshold and Timeout Interrupt

This block sits between a serial deserializer and the host side of a serial port. Each time the deserializer finishes a character it pulses a strobe with the received byte. The block stores the byte, reports that data is waiting, flags lost characters, and raises a receive interrupt. Parity and framing checks belong to the deserializer and are not part of this block.

There are two storage modes, chosen by `mode_fifo_i`, which is only changed while reset is asserted. In single-buffer mode one holding register keeps the latest byte. A new byte that arrives before the host has read the previous one replaces it and sets the overrun flag. In FIFO mode a 16-entry queue collects bytes in arrival order, and the host reads the oldest one. A byte that arrives while the queue is full is dropped and sets overrun. In FIFO mode the interrupt fires when the queue holds more bytes than a selectable trigger level. It also fires when data has sat unread for four character times, measured with an oversampling baud tick.

Top module: `uart_rx_buf`

## Requirements
- R1: After reset, `data_rdy_o`, `overrun_o` and `rx_irq_o` are all 0.
- R2: In single-buffer mode, a `rx_valid_i` pulse loads `rx_data_i` into the holding register. From the next cycle `rd_data_o` shows that byte and `data_rdy_o` is 1.
- R3: In single-buffer mode, a `rd_i` pulse with no `rx_valid_i` in the same cycle clears `data_rdy_o` on the next cycle.
- R4: In single-buffer mode, a `rx_valid_i` while `data_rdy_o` is 1 and `rd_i` is 0 sets `overrun_o`, and the new byte replaces the old one.
- R5: In FIFO mode, bytes are returned in arrival order. `rd_data_o` shows the oldest stored byte, and `rd_i` removes it when the queue is not empty.
- R6: In FIFO mode, `data_rdy_o` is 1 exactly when the queue holds at least one byte.
- R7: In FIFO mode, a `rx_valid_i` while 16 bytes are stored and no read happens in the same cycle drops the byte and sets `overrun_o`. With a read in the same cycle, the byte is accepted.
- R8: A `clr_ovr_i` pulse clears `overrun_o` on the next cycle. A new overrun event in the same cycle takes priority over the clear.
- R9: In FIFO mode with `rx_ie_i`=1, `rx_irq_o` is 1 while the stored count is above the trigger level. `thr_sel_i` codes 00, 01, 10 and 11 select levels 1, 4, 8 and 14.
- R10: In FIFO mode, once the queue has held data through 640 `baud_tick_i` pulses (4 characters of 10 bits at 16 ticks each) with no push and no read, a timeout becomes pending. The timeout drives `rx_irq_o` when `rx_ie_i`=1.
- R11: A host read in FIFO mode clears a pending timeout. Every push and every read restarts the tick count.
- R12: With `rx_ie_i`=0, `rx_irq_o` is 0. In single-buffer mode, `rx_irq_o` equals `rx_ie_i` AND `data_rdy_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_fifo_i | input | 1 | 1 selects FIFO mode, 0 selects single-buffer mode |
| thr_sel_i | input | 2 | Trigger level code for FIFO mode |
| rx_ie_i | input | 1 | Receive interrupt enable |
| baud_tick_i | input | 1 | Oversampling tick, 16 per bit period |
| rx_valid_i | input | 1 | Character-complete strobe from the deserializer |
| rx_data_i | input | 8 | Received byte |
| rd_i | input | 1 | Host read strobe for the receive data |
| clr_ovr_i | input | 1 | Host strobe that clears the overrun flag |
| rd_data_o | output | 8 | Receive data seen by the host |
| data_rdy_o | output | 1 | Data waiting |
| overrun_o | output | 1 | A character was lost |
| rx_irq_o | output | 1 | Receive interrupt |

## Verification
A corrupted queue pointer or count shows up on the first read that follows. It can appear as a byte out of order on `rd_data_o`, or as `data_rdy_o` disagreeing with the number of bytes pushed, one cycle after the bad update. A wrong trigger comparison changes `rx_irq_o` in the cycle after the push that crosses the level. A timeout counter that is off by even one tick is caught because the bench checks the exact cycle in which the interrupt appears after 640 ticks. Overrun handling is checked on the cycle after the seventeenth push, and again by draining the queue to confirm which bytes survived.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned DATA_W       = 8;
  localparam int unsigned FIFO_DEPTH   = 16;
  localparam int unsigned TICKS_PER_BIT = 16;
  localparam int unsigned BITS_PER_CHAR = 10;
  localparam int unsigned TMO_CHARS    = 4;

  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  din_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_i)  rd_q <= nxt(rd_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout_o  = mem_q[rd_q];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/rx_tmo.sv
module rx_tmo #(
  parameter int unsigned LIMIT = 640,
  localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic restart_i,
  input  logic clr_i,
  output logic pend_o
);
  logic [TW-1:0] cnt_q;
  logic          pend_q;
  logic          hit;

  assign hit = en_i && !restart_i && tick_i && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (!en_i || restart_i || hit) cnt_q <= '0;
      else if (tick_i)               cnt_q <= cnt_q + TW'(1);
      if (clr_i)    pend_q <= 1'b0;
      else if (hit) pend_q <= 1'b1;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_rx_buf.sv
module uart_rx_buf
  import uart_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_fifo_i,
  input  logic [1:0]        thr_sel_i,
  input  logic              rx_ie_i,
  input  logic              baud_tick_i,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rd_i,
  input  logic              clr_ovr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              data_rdy_o,
  output logic              overrun_o,
  output logic              rx_irq_o
);
  localparam int unsigned CW        = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned TMO_TICKS = TMO_CHARS * BITS_PER_CHAR * TICKS_PER_BIT;

  logic [DATA_W-1:0] f_dout, hold_q;
  logic [CW-1:0]     f_cnt;
  logic              f_full, f_empty, f_push, f_pop;
  logic              hold_rdy_q, ovr_q, tmo_pend;
  logic              ovr_set, above;

  assign f_pop  = mode_fifo_i && rd_i && !f_empty;
  assign f_push = mode_fifo_i && rx_valid_i && (!f_full || f_pop);

  rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (f_push),
    .pop_i  (f_pop),
    .din_i  (rx_data_i),
    .dout_o (f_dout),
    .cnt_o  (f_cnt),
    .full_o (f_full),
    .empty_o(f_empty)
  );

  rx_tmo #(.LIMIT(TMO_TICKS)) u_tmo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (mode_fifo_i && !f_empty),
    .tick_i   (baud_tick_i),
    .restart_i(f_push || f_pop),
    .clr_i    (mode_fifo_i && rd_i),
    .pend_o   (tmo_pend)
  );

  // single-buffer holding register: newest byte always wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= '0;
      hold_rdy_q <= 1'b0;
    end else if (!mode_fifo_i) begin
      if (rx_valid_i) begin
        hold_q     <= rx_data_i;
        hold_rdy_q <= 1'b1;
      end else if (rd_i) begin
        hold_rdy_q <= 1'b0;
      end
    end
  end

  assign ovr_set = mode_fifo_i ? (rx_valid_i && !f_push)
                               : (rx_valid_i && hold_rdy_q && !rd_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (ovr_set)   ovr_q <= 1'b1;
    else if (clr_ovr_i) ovr_q <= 1'b0;
  end

  assign above      = int'(f_cnt) > int'(trig_level(thr_sel_i));
  assign rd_data_o  = mode_fifo_i ? f_dout : hold_q;
  assign data_rdy_o = mode_fifo_i ? !f_empty : hold_rdy_q;
  assign overrun_o  = ovr_q;
  assign rx_irq_o   = rx_ie_i && (mode_fifo_i ? (above || tmo_pend) : hold_rdy_q);
endmodule

// File: rtl/uart_rx_buf_chk.sv
module uart_rx_buf_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       mode_fifo_i,
  input logic [1:0] thr_sel_i,
  input logic       rx_ie_i,
  input logic       baud_tick_i,
  input logic       rx_valid_i,
  input logic [7:0] rx_data_i,
  input logic       rd_i,
  input logic       clr_ovr_i,
  input logic [7:0] rd_data_o,
  input logic       data_rdy_o,
  input logic       overrun_o,
  input logic       rx_irq_o
);
  // R2
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_fifo_i && $past(!mode_fifo_i) && $past(rx_valid_i))
      |-> (data_rdy_o && rd_data_o == $past(rx_data_i)));

  // R3
  single_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_fifo_i && $past(!mode_fifo_i) && $past(rd_i) && !$past(rx_valid_i))
      |-> !data_rdy_o);

  // R4
  single_ovr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_fifo_i && $past(!mode_fifo_i) && $past(rx_valid_i && data_rdy_o && !rd_i))
      |-> overrun_o);

  // R6
  fifo_rdy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_fifo_i && $past(mode_fifo_i) && $past(rx_valid_i)) |-> data_rdy_o);

  // R8
  ovr_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(clr_ovr_i) && !$past(rx_valid_i)) |-> !overrun_o);

  // R12
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ie_i |-> !rx_irq_o);
endmodule

bind uart_rx_buf uart_rx_buf_chk u_chk (.*);

// File: tb/uart_rx_buf_tb_top.sv
module uart_rx_buf_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 640;
  localparam int DEPTH      = 16;

  logic clk = 0, rst_n = 0;
  logic mode = 0, ie = 0, tick = 0, valid = 0, rd = 0, clr = 0;
  logic [1:0] thr = 0;
  logic [7:0] din = 0;
  logic [7:0] rdata;
  logic rdy, ovr, irq;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_buf dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_fifo_i(mode), .thr_sel_i(thr),
    .rx_ie_i(ie), .baud_tick_i(tick), .rx_valid_i(valid), .rx_data_i(din),
    .rd_i(rd), .clr_ovr_i(clr), .rd_data_o(rdata), .data_rdy_o(rdy),
    .overrun_o(ovr), .rx_irq_o(irq)
  );

  // reference model
  logic [7:0] m_q[$];
  logic [7:0] m_hold;
  bit m_dr, m_ovr, m_pend;
  int m_cnt;

  function automatic int lvl(input logic [1:0] c);
    return (c == 2'b00) ? 1 : (c == 2'b01) ? 4 : (c == 2'b10) ? 8 : 14;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit pop, push, setov;
    if (!rst_n) begin
      m_q.delete(); m_hold = 0; m_dr = 0; m_ovr = 0; m_pend = 0; m_cnt = 0;
    end else begin
      if (mode) begin
        pop   = rd && m_q.size() > 0;
        push  = valid && (m_q.size() < DEPTH || pop);
        setov = valid && !push;
        if (m_q.size() == 0 || pop || push) m_cnt = 0;
        else if (tick) begin
          if (m_cnt == TMO - 1) begin m_cnt = 0; m_pend = 1; end
          else m_cnt++;
        end
        if (rd) m_pend = 0;
        if (pop) void'(m_q.pop_front());
        if (push) m_q.push_back(din);
      end else begin
        setov = valid && m_dr && !rd;
        if (valid) begin m_hold = din; m_dr = 1; end
        else if (rd) m_dr = 0;
      end
      if (setov) m_ovr = 1;
      else if (clr) m_ovr = 0;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s at %0t actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mode) begin
        check("R6 data_rdy", rdy, m_q.size() > 0);
        if (m_q.size() > 0) check("R5 rd_data", rdata, m_q[0]);
        check("R7 overrun", ovr, m_ovr);
        check("R9/R10 irq", irq, ie && (m_q.size() > lvl(thr) || m_pend));
      end else begin
        check("R3 data_rdy", rdy, m_dr);
        if (m_dr) check("R2 rd_data", rdata, m_hold);
        check("R4 overrun", ovr, m_ovr);
        check("R12 irq", irq, ie && m_dr);
      end
    end
  end

  task automatic step(input bit v, input logic [7:0] d, input bit r, input bit c, input bit t);
    @(negedge clk); #1;
    valid = v; din = d; rd = r; clr = c; tick = t;
  endtask

  task automatic do_reset(input bit m, input logic [1:0] th, input bit e);
    @(negedge clk); #1;
    rst_n = 0; valid = 0; rd = 0; clr = 0; tick = 0;
    mode = m; thr = th; ie = e;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    miscompares++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset(1, 2'b00, 1);
    @(negedge clk);
    check("R1 data_rdy", rdy, 0);
    check("R1 overrun", ovr, 0);
    check("R1 irq", irq, 0);

    // R2, R4, R8: single-buffer overwrite and overrun clear
    do_reset(0, 2'b00, 1);
    step(1, 8'hA5, 0, 0, 0);
    step(1, 8'h3C, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R2 newest byte kept", rdata, 8'h3C);
    check("R4 overrun set", ovr, 1);
    check("R12 single irq", irq, 1);
    step(0, 0, 0, 1, 0);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R8 overrun cleared", ovr, 0);
    check("R3 data_rdy cleared", rdy, 0);
    // R8 set wins over clear
    step(1, 8'h11, 0, 0, 0);
    step(1, 8'h22, 0, 1, 0);
    step(0, 0, 0, 0, 0);
    check("R8 set beats clear", ovr, 1);

    // R7: fill FIFO to 17, overrun and drop
    do_reset(1, 2'b11, 1);
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i + 8'h40), 0, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R7 overrun on full", ovr, 1);
    check("R9 irq above 14", irq, 1);
    for (int i = 0; i < DEPTH; i++) begin
      step(0, 0, 0, 0, 0);
      check("R5 order", rdata, 8'(i + 8'h40));
      step(0, 0, 1, 0, 0);
    end
    step(0, 0, 0, 0, 0);
    check("R6 empty after drain", rdy, 0);

    // R10, R11: exact timeout cycle and clear by read
    do_reset(1, 2'b11, 1);
    step(1, 8'h01, 0, 0, 0);
    step(1, 8'h02, 0, 0, 0);
    step(0, 0, 0, 0, 1);
    repeat (TMO - 1) step(0, 0, 0, 0, 1);
    check("R10 no irq before 640 ticks", irq, 0);
    step(0, 0, 0, 0, 1);
    check("R10 irq at 640 ticks", irq, 1);
    step(0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0);
    check("R11 read clears timeout", irq, 0);
    check("R11 data remains", rdy, 1);

    // R9: threshold codes
    for (int c = 0; c < 4; c++) begin
      do_reset(1, 2'(c), 1);
      for (int i = 0; i < lvl(2'(c)); i++) step(1, 8'(i), 0, 0, 0);
      step(0, 0, 0, 0, 0);
      check("R9 at level no irq", irq, 0);
      step(1, 8'hEE, 0, 0, 0);
      step(0, 0, 0, 0, 0);
      check("R9 above level irq", irq, 1);
    end

    // random segments
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < 8; s++) begin
      do_reset(s[0], 2'($urandom_range(0, 3)), (s % 4) != 3);
      for (int n = 0; n < 3000; n++)
        step(($urandom_range(0, 3) == 0), 8'($urandom), ($urandom_range(0, 4) == 0),
             ($urandom_range(0, 40) == 0), ($urandom_range(0, 1) == 1));
    end
    step(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule